// File: doc/BRIEF.md
# Serial Transceiver Power-Down Controller

This block decides when the line drivers of a multi-channel serial transceiver are powered. Two control pins select one of three modes. An active-low manual-off pin forces the drivers into high impedance. An always-on pin keeps them driven. When the manual-off pin is high and the always-on pin is low, the block is in activity-timed mode. In that mode the drivers stay enabled only while some transmitter data input or receiver activity input has toggled within an inactivity window. A falling edge on the always-on pin also restarts that window, so a host that drops out of always-on mode keeps its drivers for one full window. The window is set in clock cycles; the default is thirty seconds at 50 MHz.

The receivers are never switched off. A line-valid flag reports whether any receiver sees a proper line level, in every mode. The flag can be wired back onto both control pins. The drivers then follow the presence of a valid line level: the block is on while a level is present and off while none is.

All pins are treated as asynchronous. They pass through a two-stage synchronizer before any decision is made, and every output is registered.

Top module: `xpd_power_ctrl`

## Requirements
- R1: While `manual_off_n` is low, `tx_en_o` is low, whatever `always_on` and the activity inputs do.
- R2: While `manual_off_n` and `always_on` are both high, `tx_en_o` is high, with or without activity.
- R3: With `manual_off_n` high and `always_on` low, a rising or falling edge on any bit of `tx_data_i` or `rx_act_i` raises `tx_en_o`. `tx_en_o` then stays high for exactly `WINDOW_CYCLES` clock cycles after the last such edge and drops to low after that.
- R4: A falling edge on `always_on` restarts the same window as an activity edge does. In timed mode this holds the drivers on for `WINDOW_CYCLES` cycles even if no input toggles.
- R5: `rx_en_o` is low only during reset. It is high from the first clock after reset in every mode.
- R6: `line_valid_o` is the OR of all bits of `rx_level_ok_i` (high means a valid level is present), in every mode.
- R7: With `line_valid_o` looped onto both `manual_off_n` and `always_on`, `tx_en_o` is high while a valid level is present and low while none is.
- R8: `pwrdn_o` is always the complement of `tx_en_o`.
- R9: An input change reaches the outputs on the third rising clock edge after it. Edges are counted only once the synchronizer holds real samples: an input that merely differs from the synchronizer's reset value right after reset counts as no activity.
- R10: During reset `tx_en_o` and `rx_en_o` are low, `pwrdn_o` is high and `line_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the timer and the synchronizers |
| rst_n | input | 1 | Active-low asynchronous reset |
| manual_off_n | input | 1 | Low forces the line drivers off |
| always_on | input | 1 | High keeps the drivers on (when manual_off_n is high); its falling edge restarts the window |
| tx_data_i | input | N_TX | Transmitter data inputs, watched for edges |
| rx_act_i | input | N_RX | Receiver line activity inputs, watched for edges |
| rx_level_ok_i | input | N_RX | Per-receiver flag: valid line level present |
| tx_en_o | output | 1 | Line driver enable; low means high impedance |
| rx_en_o | output | 1 | Receiver enable |
| line_valid_o | output | 1 | High when any receiver sees a valid level |
| pwrdn_o | output | 1 | High while the drivers are powered down |

## Verification
The hardest situation to reach is the end of the inactivity window. The block must sit in timed mode for the full window with no toggles on any of four activity inputs. Then `tx_en_o` must fall on the exact cycle, and the always-on falling edge must open that window without any data transition. The bench builds the design with a short window and drives long directed quiet stretches: one after a single data toggle and one after leaving always-on mode. Random stimulus keeps toggles sparse enough that windows expire often. A loopback phase ties the line-valid output back onto both control pins while the level flags change.

// File: rtl/xpd_pkg.sv
package xpd_pkg;

    typedef enum logic [1:0] {
        PM_OFF   = 2'd0,
        PM_TIMED = 2'd1,
        PM_ON    = 2'd2
    } pmode_e;

    typedef struct packed {
        logic tx_en;
        logic pwrdn;
        logic valid;
        logic rx_en;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{tx_en: 1'b0, pwrdn: 1'b1, valid: 1'b0, rx_en: 1'b0};

    function automatic pmode_e decode_mode(input logic off_n, input logic on);
        if (!off_n) begin
            return PM_OFF;
        end
        if (on) begin
            return PM_ON;
        end
        return PM_TIMED;
    endfunction

endpackage

// File: rtl/xpd_sync.sv
module xpd_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;

endmodule

// File: rtl/xpd_activity.sv
module xpd_activity #(
    parameter int N_ACT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ACT-1:0] act_s,
    input  logic             on_s,
    output logic             restart
);

    localparam logic [1:0] FILL_DONE = 2'd3;

    typedef struct packed {
        logic [N_ACT-1:0] prev;
        logic             on_prev;
        logic [1:0]       fill;
    } act_t;

    act_t st_d, st_q;
    logic [N_ACT-1:0] bit_edge;
    logic armed;
    logic any_edge;
    logic on_fall;

    for (genvar g = 0; g < N_ACT; g++) begin : g_edge
        assign bit_edge[g] = act_s[g] ^ st_q.prev[g];
    end

    assign armed    = (st_q.fill == FILL_DONE);
    assign any_edge = |bit_edge;
    assign on_fall  = st_q.on_prev & ~on_s;
    assign restart  = armed & (any_edge | on_fall);

    always_comb begin
        st_d         = st_q;
        st_d.prev    = act_s;
        st_d.on_prev = on_s;
        if (!armed) begin
            st_d.fill = st_q.fill + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/xpd_idle_timer.sv
module xpd_idle_timer #(
    parameter int WINDOW_CYCLES = 1_500_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic open_d
);

    localparam int CW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WINDOW_CYCLES);

    logic [CW-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (restart) begin
            rem_d = LOAD;
        end else if (rem_q != '0) begin
            rem_d = rem_q - CW'(1);
        end
    end

    assign open_d = (rem_d != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

endmodule

// File: rtl/xpd_power_ctrl.sv
module xpd_power_ctrl
    import xpd_pkg::*;
#(
    parameter int N_TX          = 2,
    parameter int N_RX          = 2,
    parameter int WINDOW_CYCLES = 1_500_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            manual_off_n,
    input  logic            always_on,
    input  logic [N_TX-1:0] tx_data_i,
    input  logic [N_RX-1:0] rx_act_i,
    input  logic [N_RX-1:0] rx_level_ok_i,
    output logic            tx_en_o,
    output logic            rx_en_o,
    output logic            line_valid_o,
    output logic            pwrdn_o
);

    localparam int N_ACT  = N_TX + N_RX;
    localparam int SYNC_W = N_ACT + N_RX + 2;

    logic [SYNC_W-1:0] raw;
    logic [SYNC_W-1:0] synced;
    logic [N_ACT-1:0]  act_s;
    logic [N_RX-1:0]   lvl_s;
    logic              on_s;
    logic              off_s;
    logic              restart;
    logic              win_open_d;
    pmode_e            mode;
    ctl_t              st_d, st_q;

    assign raw = {manual_off_n, always_on, rx_level_ok_i, rx_act_i, tx_data_i};

    xpd_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (synced)
    );

    assign act_s = synced[N_ACT-1:0];
    assign lvl_s = synced[N_ACT +: N_RX];
    assign on_s  = synced[SYNC_W-2];
    assign off_s = synced[SYNC_W-1];

    xpd_activity #(.N_ACT(N_ACT)) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_s   (act_s),
        .on_s    (on_s),
        .restart (restart)
    );

    xpd_idle_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .open_d  (win_open_d)
    );

    assign mode = decode_mode(off_s, on_s);

    always_comb begin
        st_d       = st_q;
        st_d.rx_en = 1'b1;
        st_d.valid = |lvl_s;
        unique case (mode)
            PM_OFF:  st_d.tx_en = 1'b0;
            PM_ON:   st_d.tx_en = 1'b1;
            default: st_d.tx_en = win_open_d;
        endcase
        st_d.pwrdn = ~st_d.tx_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_en_o      = st_q.tx_en;
    assign pwrdn_o      = st_q.pwrdn;
    assign line_valid_o = st_q.valid;
    assign rx_en_o      = st_q.rx_en;

endmodule

// File: rtl/xpd_chk.sv
module xpd_chk #(
    parameter int N_RX = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            off_s,
    input logic            on_s,
    input logic [N_RX-1:0] lvl_s,
    input logic            restart,
    input logic            tx_en_o,
    input logic            pwrdn_o,
    input logic            rx_en_o,
    input logic            line_valid_o
);

    a_r1_manual_off: assert property (@(posedge clk) disable iff (!rst_n)
        !off_s |=> !tx_en_o);

    a_r2_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        (off_s && on_s) |=> tx_en_o);

    a_r3_restart_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && off_s && !on_s) |=> tx_en_o);

    a_r5_rx_stays: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_o |=> rx_en_o);

    a_r6_valid_high: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl_s) |=> line_valid_o);

    a_r6_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(|lvl_s) |=> !line_valid_o);

    a_r8_pwrdn_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_o == !tx_en_o);

endmodule

bind xpd_power_ctrl xpd_chk #(.N_RX(N_RX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .off_s        (off_s),
    .on_s         (on_s),
    .lvl_s        (lvl_s),
    .restart      (restart),
    .tx_en_o      (tx_en_o),
    .pwrdn_o      (pwrdn_o),
    .rx_en_o      (rx_en_o),
    .line_valid_o (line_valid_o)
);

// File: tb/tb_xpd_power_ctrl.sv
module tb_xpd_power_ctrl;

    localparam int NT = 2;
    localparam int NR = 2;
    localparam int W  = 40;
    localparam int NA = NT + NR;
    localparam int SW = NA + NR + 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          drv_off_n, drv_on, loop_en;
    logic [NT-1:0] tx;
    logic [NR-1:0] rx, lvl;
    logic          off_pin, on_pin;
    logic          tx_en, rx_en, lv, pd;

    assign off_pin = loop_en ? lv : drv_off_n;
    assign on_pin  = loop_en ? lv : drv_on;

    xpd_power_ctrl #(.N_TX(NT), .N_RX(NR), .WINDOW_CYCLES(W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .manual_off_n  (off_pin),
        .always_on     (on_pin),
        .tx_data_i     (tx),
        .rx_act_i      (rx),
        .rx_level_ok_i (lvl),
        .tx_en_o       (tx_en),
        .rx_en_o       (rx_en),
        .line_valid_o  (lv),
        .pwrdn_o       (pd)
    );

    // staged stimulus, applied at the falling edge
    logic          n_rst_n, n_off_n, n_on, n_loop;
    logic [NT-1:0] n_tx;
    logic [NR-1:0] n_rx, n_lvl;

    // reference model state
    logic [SW-1:0] ms1, ms2, mp;
    int            mfill, mrem;
    bit            mtx, mlv, mrx, in_reset;
    string         mtag, cause;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic [SW-1:0] v, input bit rst_now, input bit looped);
        logic off, on, actchg, onfall, rs;
        int   rem_d;
        bit   tx_d;
        if (rst_now) begin
            ms1 = '0; ms2 = '0; mp = '0; mfill = 0; mrem = 0;
            mtx = 0; mlv = 0; mrx = 0; in_reset = 1; mtag = "R10"; cause = "R3";
            return;
        end
        in_reset = 0;
        off    = ms2[SW-1];
        on     = ms2[SW-2];
        actchg = (ms2[NA-1:0] != mp[NA-1:0]);
        onfall = mp[SW-2] & ~ms2[SW-2];
        rs     = (mfill == 3) && (actchg || onfall);
        if (rs) cause = (onfall && !actchg) ? "R4" : "R3";
        rem_d  = rs ? W : (mrem > 0 ? mrem - 1 : 0);
        tx_d   = !off ? 1'b0 : (on ? 1'b1 : (rem_d != 0));
        if (looped)          mtag = "R7";
        else if (mfill < 3)  mtag = "R9";
        else if (!off)       mtag = "R1";
        else if (on)         mtag = "R2";
        else                 mtag = cause;
        mlv   = |ms2[NA +: NR];
        mrx   = 1'b1;
        mtx   = tx_d;
        mrem  = rem_d;
        mp    = ms2;
        ms2   = ms1;
        ms1   = v;
        mfill = (mfill < 3) ? mfill + 1 : 3;
    endtask

    task automatic compare();
        chk(tx_en == mtx, mtag, "tx_en", int'(tx_en), int'(mtx));
        chk(pd == !mtx, in_reset ? "R10" : "R8", "pwrdn", int'(pd), int'(!mtx));
        chk(lv == mlv, in_reset ? "R10" : "R6", "line_valid", int'(lv), int'(mlv));
        chk(rx_en == mrx, in_reset ? "R10" : "R5", "rx_en", int'(rx_en), int'(mrx));
    endtask

    task automatic tick();
        logic [SW-1:0] v;
        bit r, lp;
        @(negedge clk);
        compare();
        rst_n     = n_rst_n;
        drv_off_n = n_off_n;
        drv_on    = n_on;
        loop_en   = n_loop;
        tx        = n_tx;
        rx        = n_rx;
        lvl       = n_lvl;
        #1;
        v  = {off_pin, on_pin, lvl, rx, tx};
        r  = !rst_n;
        lp = loop_en;
        @(posedge clk);
        #1;
        model_step(v, r, lp);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; drv_off_n = 1; drv_on = 0; loop_en = 0;
        tx = '1; rx = '0; lvl = '0;
        n_rst_n = 0; n_off_n = 1; n_on = 0; n_loop = 0;
        n_tx = '1; n_rx = '0; n_lvl = '0;
        model_step('0, 1'b1, 1'b0);
        #1;
        // R10: reset values with the clock already running
        run(4);
        chk(tx_en == 0 && pd == 1 && lv == 0 && rx_en == 0, "R10", "reset outputs",
            int'({tx_en, pd, lv, rx_en}), 4'b0100);

        // R9: idle-high data after reset is not activity
        n_rst_n = 1;
        run(20);
        chk(tx_en == 0, "R9", "no credit after reset", int'(tx_en), 0);

        // R3: single toggle, then a quiet window until expiry
        n_tx[0] = 1'b0;
        run(3);
        chk(tx_en == 1, "R3", "enable after toggle", int'(tx_en), 1);
        run(W - 3);
        chk(tx_en == 1, "R3", "still open before expiry", int'(tx_en), 1);
        run(4);
        chk(tx_en == 0, "R3", "closed after window", int'(tx_en), 0);

        // R4: leave always-on without any toggle
        n_on = 1;
        run(12);
        n_on = 0;
        run(W);
        chk(tx_en == 1, "R4", "window after on fall", int'(tx_en), 1);
        run(10);
        chk(tx_en == 0, "R4", "window expired", int'(tx_en), 0);

        // R1: manual off with activity and always-on
        n_off_n = 0; n_on = 1;
        for (int i = 0; i < 40; i++) begin
            n_rx = NR'($urandom);
            tick();
        end
        chk(tx_en == 0, "R1", "manual off holds", int'(tx_en), 0);

        // R2: always on with no activity
        n_off_n = 1; n_on = 1;
        run(W + 20);
        chk(tx_en == 1, "R2", "always on holds", int'(tx_en), 1);

        // R6: level flags in several patterns
        for (int p = 0; p < 4; p++) begin
            n_lvl = NR'(p);
            run(6);
            chk(lv == (p != 0), "R6", "valid OR", int'(lv), int'(p != 0));
        end

        // R7: loopback of the valid flag onto both control pins
        n_loop = 1;
        n_lvl = 2'b01; run(15);
        chk(tx_en == 1, "R7", "loop level present", int'(tx_en), 1);
        n_lvl = 2'b00; run(15);
        chk(tx_en == 0, "R7", "loop level absent", int'(tx_en), 0);
        n_lvl = 2'b10; run(15);
        chk(tx_en == 1, "R7", "loop level back", int'(tx_en), 1);
        n_loop = 0;

        // random phase: sparse toggles so windows expire often
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) == 0) begin
                n_off_n = ($urandom_range(3) != 0);
                n_on    = $urandom_range(1) == 1;
            end
            if ($urandom_range(60) == 0) begin
                int b;
                b = $urandom_range(NA - 1);
                if (b < NT) n_tx[b] = ~n_tx[b];
                else        n_rx[b - NT] = ~n_rx[b - NT];
            end
            if ($urandom_range(49) == 0) n_lvl = NR'($urandom);
            if ($urandom_range(499) == 0) n_loop = ~n_loop;
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule